// File: doc/BRIEF.md
# Bidirectional Binary Counter with Parallel Load and Cascade Flags

This block is a small binary counter that steps up or down under two separate single-cycle strobes, all sampled on one system clock. A parallel value can be written into it, and a clear input forces it to zero at once, without waiting for a clock edge. The default width is four bits.

Two active-low flag outputs mark the cycle in which the counter is about to pass its terminal value. The up flag marks a step from all ones to zero. The down flag marks a step from zero to all ones. To build a wider counter, chain stages: invert the lower stage's flags and feed them to the next stage's up and down strobes. Clear and load go to all stages in parallel.

Top module: `updown_counter`

## Requirements
- R1: While `clr` is high, `count` is 0 at once, with no clock edge needed. It stays 0 whatever the other inputs do, and both flags are high.
- R2: With `clr` low and `load_n` low, `count` takes the value of `din` at the next rising clock edge, whatever the strobes are.
- R3: With `clr` low, `load_n` high, `up` high and `down` low, `count` goes up by one at the next rising edge.
- R4: With `clr` low, `load_n` high, `down` high and `up` low, `count` goes down by one at the next rising edge.
- R5: Counting up from all ones (15 at default width) gives 0. Counting down from 0 gives all ones.
- R6: With `clr` low and `load_n` high, `count` holds its value if both strobes are high or both are low.
- R7: `carry_n` is low exactly when `count` is all ones, `up` is high, `down` is low, `load_n` is high and `clr` is low. Otherwise it is high. It is combinational in the same cycle.
- R8: `borrow_n` is low exactly when `count` is 0, `down` is high, `up` is low, `load_n` is high and `clr` is low. Otherwise it is high.
- R9: Two stages form a counter of twice the width that counts up and down modulo 2^(2·WIDTH). For this, the upper stage takes the inverted `carry_n` of the lower stage as `up` and the inverted `borrow_n` as `down`, and both stages share `clr` and `load_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| clr | input | 1 | Active-high clear, acts immediately |
| load_n | input | 1 | Active-low synchronous parallel load |
| up | input | 1 | Count-up strobe, active high |
| down | input | 1 | Count-down strobe, active high |
| din | input | WIDTH | Parallel load value |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low flag: an up step from all ones is happening |
| borrow_n | output | 1 | Active-low flag: a down step from zero is happening |

## Verification
The bench uses the default width of four. This makes an exhaustive sweep practical: every one of the sixteen start values is loaded and then stepped up, stepped down, given both strobes, and given no strobe. Each step is compared with modular arithmetic. The same sweep covers each terminal flag at its one firing value and at all fifteen values where it must stay high. Two further four-bit instances are chained into an eight-bit counter. This brings the carry and borrow ripple across all 256 values within reach, in both directions.

// File: rtl/updown_counter_pkg.sv
package updown_counter_pkg;

    // Operation selected for the next clock edge, in priority order
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } cnt_op_e;

endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import updown_counter_pkg::*;
(
    input  logic    clr,
    input  logic    load_n,
    input  logic    up,
    input  logic    down,
    output cnt_op_e op
);

    always_comb begin
        if (clr)
            op = OP_HOLD;
        else if (!load_n)
            op = OP_LOAD;
        else if (up && !down)
            op = OP_INC;
        else if (down && !up)
            op = OP_DEC;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/cnt_term_flags.sv
module cnt_term_flags
    import updown_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    always_comb begin
        carry_n  = !((op == OP_INC) && (count == TOP));
        borrow_n = !((op == OP_DEC) && (count == '0));
    end

endmodule

// File: rtl/updown_counter.sv
module updown_counter
    import updown_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load_n,
    input  logic             up,
    input  logic             down,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    cnt_op_e    op;

    cnt_op_decode u_decode (
        .clr    (clr),
        .load_n (load_n),
        .up     (up),
        .down   (down),
        .op     (op)
    );

    cnt_term_flags #(.WIDTH(WIDTH)) u_flags (
        .op       (op),
        .count    (state_q.count),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_LOAD: state_d.count = din;
            OP_INC:  state_d.count = state_q.count + ONE;
            OP_DEC:  state_d.count = state_q.count - ONE;
            default: state_d.count = state_q.count;
        endcase
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign count = state_q.count;

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (clr)
        !load_n |=> count == $past(din));

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (clr)
        (load_n && up && !down) |=> count == $past(count) + ONE);

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (clr)
        (load_n && down && !up) |=> count == $past(count) - ONE);

    // R5
    up_wrap_chk: assert property (@(posedge clk) disable iff (clr)
        !carry_n |=> count == '0);

    // R5
    down_wrap_chk: assert property (@(posedge clk) disable iff (clr)
        !borrow_n |=> count == TOP);

    // R6
    both_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (load_n && up == down) |=> $stable(count));

    // R7
    carry_term_chk: assert property (@(posedge clk) disable iff (clr)
        !carry_n |-> (count == TOP && up && !down && load_n));

    // R8
    borrow_term_chk: assert property (@(posedge clk) disable iff (clr)
        !borrow_n |-> (count == '0 && down && !up && load_n));

    // R1
    always_comb begin
        if (clr) begin
            clr_flags_chk: assert (carry_n && borrow_n);
        end
    end

endmodule

// File: tb/test_updown_counter.sv
`timescale 1ns/1ps
module test_updown_counter;

    localparam int W = 4;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         clr = 1'b1;
    logic         load_n = 1'b1;
    logic         up = 1'b0;
    logic         dn = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] cnt;
    logic         carry_n, borrow_n;

    // cascade pair
    logic           cclr = 1'b1;
    logic           cload_n = 1'b1;
    logic           cup = 1'b0;
    logic           cdn = 1'b0;
    logic [2*W-1:0] cdin = '0;
    logic [W-1:0]   lo_cnt, hi_cnt;
    logic           lo_c, lo_b, hi_c, hi_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    updown_counter #(.WIDTH(W)) i_updown_counter (
        .clk(clk), .clr(clr), .load_n(load_n), .up(up), .down(dn),
        .din(din), .count(cnt), .carry_n(carry_n), .borrow_n(borrow_n)
    );

    updown_counter #(.WIDTH(W)) i_lo (
        .clk(clk), .clr(cclr), .load_n(cload_n), .up(cup), .down(cdn),
        .din(cdin[W-1:0]), .count(lo_cnt), .carry_n(lo_c), .borrow_n(lo_b)
    );

    updown_counter #(.WIDTH(W)) i_hi (
        .clk(clk), .clr(cclr), .load_n(cload_n), .up(!lo_c), .down(!lo_b),
        .din(cdin[2*W-1:W]), .count(hi_cnt), .carry_n(hi_c), .borrow_n(hi_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at negedge, let combinational flags settle
    task automatic drive(input logic u, input logic d, input logic l, input int v);
        @(negedge clk);
        up = u; dn = d; load_n = l; din = v[W-1:0];
        #1;
    endtask

    task automatic edge_settle();
        @(posedge clk);
        #1;
    endtask

    task automatic load_val(input int v);
        drive(1'b0, 1'b0, 1'b0, v);
        edge_settle();
        chk("R2 load", int'(cnt), v);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        // R1 reset state
        chk("R1 count under clr", int'(cnt), 0);
        chk("R1 carry_n under clr", int'(carry_n), 1);
        chk("R1 borrow_n under clr", int'(borrow_n), 1);
        @(negedge clk);
        clr = 1'b0;

        for (int v = 0; v < M; v++) begin
            // R3 / R5 / R7
            load_val(v);
            drive(1'b1, 1'b0, 1'b1, 0);
            chk("R7 carry_n", int'(carry_n), (v == M-1) ? 0 : 1);
            chk("R8 borrow_n idle on up", int'(borrow_n), 1);
            edge_settle();
            chk("R3 R5 up step", int'(cnt), (v + 1) % M);

            // R4 / R5 / R8
            load_val(v);
            drive(1'b0, 1'b1, 1'b1, 0);
            chk("R8 borrow_n", int'(borrow_n), (v == 0) ? 0 : 1);
            chk("R7 carry_n idle on down", int'(carry_n), 1);
            edge_settle();
            chk("R4 R5 down step", int'(cnt), (v + M - 1) % M);

            // R6 both strobes
            load_val(v);
            drive(1'b1, 1'b1, 1'b1, 0);
            chk("R7 carry_n both", int'(carry_n), 1);
            chk("R8 borrow_n both", int'(borrow_n), 1);
            edge_settle();
            chk("R6 hold both", int'(cnt), v);
            // R6 no strobe
            drive(1'b0, 1'b0, 1'b1, 0);
            edge_settle();
            chk("R6 hold idle", int'(cnt), v);

            // R2 load beats strobes
            drive(1'b1, 1'b0, 1'b0, (M - 1) - v);
            chk("R7 carry_n during load", int'(carry_n), 1);
            edge_settle();
            chk("R2 load over up", int'(cnt), (M - 1) - v);
            drive(1'b0, 1'b1, 1'b0, v);
            chk("R8 borrow_n during load", int'(borrow_n), 1);
            edge_settle();
            chk("R2 load over down", int'(cnt), v);
        end

        // R1 immediate clear, beats load and up
        load_val(9);
        @(negedge clk);
        up = 1'b1; dn = 1'b0; load_n = 1'b0; din = 4'd6;
        clr = 1'b1;
        #1;
        chk("R1 immediate clear", int'(cnt), 0);
        edge_settle();
        chk("R1 clear over load", int'(cnt), 0);
        load_n = 1'b1; din = 4'd15;
        edge_settle();
        chk("R1 clear over up", int'(cnt), 0);
        chk("R1 carry_n under clr", int'(carry_n), 1);
        @(negedge clk);
        clr = 1'b0; up = 1'b0;

        // R9 cascade
        @(negedge clk);
        cclr = 1'b0;
        begin
            int model = 0;
            for (int s = 0; s < 300; s++) begin
                @(negedge clk);
                cup = 1'b1; cdn = 1'b0;
                edge_settle();
                model = (model + 1) % (M * M);
                chk("R9 cascade up", int'({hi_cnt, lo_cnt}), model);
            end
            @(negedge clk);
            cup = 1'b0; cload_n = 1'b0; cdin = 8'h05;
            edge_settle();
            model = 5;
            chk("R9 cascade load", int'({hi_cnt, lo_cnt}), model);
            @(negedge clk);
            cload_n = 1'b1;
            for (int s = 0; s < 300; s++) begin
                @(negedge clk);
                cup = 1'b0; cdn = 1'b1;
                edge_settle();
                model = (model + M * M - 1) % (M * M);
                chk("R9 cascade down", int'({hi_cnt, lo_cnt}), model);
            end
            @(negedge clk);
            cdn = 1'b0;
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule